// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block turns a set of external interrupt wires into delivery messages for processors. Each input pin has its own redirection entry. The entry holds the vector the pin raises, how the message is delivered, which processor it is sent to, whether the pin is active high or active low, whether it is edge or level sensitive, and a mask bit. Pins are synchronised, and polarity is applied before any edge or level decision. Pending pins are then sent one at a time on a valid/ready message port. The lowest-numbered pin is sent first.

Software reaches every internal register through one pair of addresses: a select register holding an index and a 32-bit window that reads or writes the register at that index. A separate end-of-interrupt address takes a vector number. Writing it releases every level-sensitive pin that uses that vector, so the pin can deliver again if its input is still active. Edges seen while a pin is masked are dropped outright, so unmasking never produces a late message.

Top module: `ioirq_ctrl`

## Requirements
- R1: After reset every entry reads back with only the mask bit set: the low word is 0x0001_0000 and the high word is 0. No message is presented.
- R2: Port address 0 is the select register and reads back its 8-bit index in bits [7:0]. Address 1 is the window onto the register at the current index. Read data appears on `reg_rdata` one cycle after the read strobe. A window read of an unused index returns 0, and a window write to one has no effect.
- R3: Index 0x01 is a read-only identification word. Bits [7:0] hold 0x21, bits [23:16] hold NUM_PINS-1, and all other bits are 0. Writes to it are ignored.
- R4: Pin n has its low word at index 0x10+2n and its high word at index 0x11+2n. The low word holds vector [7:0], delivery mode [10:8], active-low [13], level [15] and mask [16]. The high word holds the 16-bit destination in [31:16]. Every other bit reads 0, and every field reads back exactly as written.
- R5: An unmasked edge pin (bit 15 = 0) delivers exactly one message for each transition of its input to the active level. Holding the input active gives no further messages.
- R6: An active-going edge on an edge pin whose mask bit is set is discarded. Clearing the mask afterwards produces no message.
- R7: A level pin (bit 15 = 1) delivers once and is then blocked until its vector is written to port address 2, bits [7:0]. A write of a different vector leaves it blocked. If the input is still active after the matching write, the pin delivers again. If the input is inactive, it does not.
- R8: A message carries the pin's vector, its destination and its 3-bit delivery mode. The mode passes through unchanged; examples are 0 fixed, 1 lowest priority, 2 PMI and 5 INIT.
- R9: When several pins are pending, the lowest-numbered pin is sent first, and at most one pin is granted per cycle.
- R10: Once `msg_valid` is high, it stays high and the vector, destination and mode stay constant until `msg_ready` is seen high.
- R11: With bit 13 set, a low input level counts as active and a high level as inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 select, 1 window, 2 end-of-interrupt |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_PINS | Asynchronous interrupt pins |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 16 | Message destination |
| msg_mode | output | 3 | Message delivery mode |

## Verification
The assertions assume that the receiver may hold `msg_ready` low for any length of time, and that software does not change an entry's vector while that pin is in service. The assertions also assume that the register strobes are one cycle wide and are never asserted together. The stimulus drives every strobe as a single-cycle pulse and reprograms entries only while their pins are idle. Pin inputs are held for several cycles, so each change passes through the synchroniser.

// File: rtl/ioirq_pkg.sv
package ioirq_pkg;
  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_WIN = 2'd1;
  localparam logic [1:0] A_EOI = 2'd2;

  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_BASE = 8'h10;
  localparam logic [7:0] VERSION  = 8'h21;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        level;
    logic        act_low;
    logic [2:0]  mode;
    logic [7:0]  vec;
  } rte_t;

  localparam rte_t RTE_RST = '{dest: 16'd0, mask: 1'b1, level: 1'b0,
                               act_low: 1'b0, mode: 3'd0, vec: 8'd0};

  function automatic logic [31:0] low_word(rte_t e);
    return {15'd0, e.mask, e.level, 1'b0, e.act_low, 2'b00, e.mode, e.vec};
  endfunction
endpackage

// File: rtl/ioirq_regs.sv
module ioirq_regs
  import ioirq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [1:0]                addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output rte_t [NUM_PINS-1:0]       cfg,
  output logic                      eoi_stb,
  output logic [7:0]                eoi_vec
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  logic [7:0]  sel;
  logic [7:0]  off;
  logic [6:0]  pin_idx;
  logic        hit_ok;
  logic        hit_hi;
  rte_t        cur;
  logic [31:0] win_val;
  logic        unused_bits;

  assign unused_bits = ^{wdata[14], wdata[12:11]};

  always_comb begin
    off     = sel - IDX_BASE;
    pin_idx = off[7:1];
    hit_hi  = off[0];
    hit_ok  = (sel >= IDX_BASE) && (int'(pin_idx) < NUM_PINS);
    cur     = RTE_RST;
    for (int i = 0; i < NUM_PINS; i++)
      if (int'(pin_idx) == i) cur = cfg[i];
    if (sel == IDX_VER)
      win_val = {8'd0, MAX_PIN, 8'd0, VERSION};
    else if (hit_ok)
      win_val = hit_hi ? {cur.dest, 16'd0} : low_word(cur);
    else
      win_val = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= 8'd0;
      rdata   <= 32'd0;
      eoi_stb <= 1'b0;
      eoi_vec <= 8'd0;
      for (int i = 0; i < NUM_PINS; i++) cfg[i] <= RTE_RST;
    end else begin
      eoi_stb <= wr && (addr == A_EOI);
      if (wr && (addr == A_EOI)) eoi_vec <= wdata[7:0];
      if (wr && (addr == A_SEL)) sel <= wdata[7:0];
      if (wr && (addr == A_WIN) && hit_ok) begin
        for (int i = 0; i < NUM_PINS; i++) begin
          if (int'(pin_idx) == i) begin
            if (hit_hi) begin
              cfg[i].dest <= wdata[31:16];
            end else begin
              cfg[i].vec     <= wdata[7:0];
              cfg[i].mode    <= wdata[10:8];
              cfg[i].act_low <= wdata[13];
              cfg[i].level   <= wdata[15];
              cfg[i].mask    <= wdata[16];
            end
          end
        end
      end
      if (rd) begin
        case (addr)
          A_SEL:   rdata <= {24'd0, sel};
          A_WIN:   rdata <= win_val;
          default: rdata <= 32'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ioirq_pin.sv
module ioirq_pin (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       mask,
  input  logic       level,
  input  logic       act_low,
  input  logic [7:0] vec,
  input  logic       eoi_stb,
  input  logic [7:0] eoi_vec,
  input  logic       take,
  output logic       req
);
  logic sync1, sync2, prev_act, edge_pend, in_svc;
  logic act;

  assign act = sync2 ^ act_low;
  assign req = level ? (act & ~mask & ~in_svc) : edge_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      prev_act  <= 1'b0;
      edge_pend <= 1'b0;
      in_svc    <= 1'b0;
    end else begin
      sync1    <= pin_in;
      sync2    <= sync1;
      prev_act <= act;
      if (mask || level)          edge_pend <= 1'b0;
      else if (act && !prev_act)  edge_pend <= 1'b1;
      else if (take)              edge_pend <= 1'b0;
      if (!level)                           in_svc <= 1'b0;
      else if (take)                        in_svc <= 1'b1;
      else if (eoi_stb && eoi_vec == vec)   in_svc <= 1'b0;
    end
  end
endmodule

// File: rtl/ioirq_arb.sv
module ioirq_arb
  import ioirq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  req,
  input  rte_t [NUM_PINS-1:0]  cfg,
  input  logic                 ready,
  output logic                 valid,
  output logic [7:0]           vec,
  output logic [15:0]          dest,
  output logic [2:0]           mode,
  output logic [NUM_PINS-1:0]  grant
);
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [IW-1:0] pick, held;
  logic          any;
  rte_t          pick_e;
  logic          unused_cfg;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick = IW'(i);
        any  = 1'b1;
      end
    end
    pick_e = RTE_RST;
    for (int i = 0; i < NUM_PINS; i++)
      if (pick == IW'(i)) pick_e = cfg[i];
    unused_cfg = pick_e.mask ^ pick_e.level ^ pick_e.act_low;
  end

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_grant
      assign grant[g] = valid && ready && (held == IW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      held  <= '0;
      vec   <= 8'd0;
      dest  <= 16'd0;
      mode  <= 3'd0;
    end else if (!valid) begin
      if (any) begin
        valid <= 1'b1;
        held  <= pick;
        vec   <= pick_e.vec;
        dest  <= pick_e.dest;
        mode  <= pick_e.mode;
      end
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ioirq_ctrl.sv
module ioirq_ctrl
  import ioirq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_mode
);
  rte_t [NUM_PINS-1:0] cfg;
  logic                eoi_stb;
  logic [7:0]          eoi_vec;
  logic [NUM_PINS-1:0] req;
  logic [NUM_PINS-1:0] grant;

  ioirq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg),
    .eoi_stb(eoi_stb), .eoi_vec(eoi_vec)
  );

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      ioirq_pin u_pin (
        .clk(clk), .rst(rst), .pin_in(irq_in[g]),
        .mask(cfg[g].mask), .level(cfg[g].level), .act_low(cfg[g].act_low),
        .vec(cfg[g].vec), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec),
        .take(grant[g]), .req(req[g])
      );
    end
  endgenerate

  ioirq_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .req(req), .cfg(cfg), .ready(msg_ready),
    .valid(msg_valid), .vec(msg_vector), .dest(msg_dest), .mode(msg_mode),
    .grant(grant)
  );
endmodule

// File: rtl/ioirq_ctrl_chk.sv
module ioirq_ctrl_chk
  import ioirq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [1:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_vector,
  input logic [15:0]         msg_dest,
  input logic [2:0]          msg_mode,
  input logic [NUM_PINS-1:0] grant
);
  localparam logic [31:0] VER_WORD = {8'd0, 8'(NUM_PINS - 1), 8'd0, VERSION};

  logic [7:0] sel_m;
  always_ff @(posedge clk) begin
    if (rst) sel_m <= 8'd0;
    else if (reg_wr && reg_addr == A_SEL) sel_m <= reg_wdata[7:0];
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !msg_valid);

  // R2
  sel_read_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == A_SEL |=> reg_rdata == {24'd0, $past(sel_m)});

  // R3
  version_read_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == A_WIN && sel_m == IDX_VER |=> reg_rdata == VER_WORD);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
      && $stable(msg_dest) && $stable(msg_mode));
endmodule

bind ioirq_ctrl ioirq_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (.*);

// File: tb/ioirq_ctrl_tb_top.sv
module ioirq_ctrl_tb_top;
  import ioirq_pkg::*;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = 32'd0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] irq_in = 8'b0000_1000;
  logic          msg_valid, msg_ready = 1'b1;
  logic [7:0]    msg_vector;
  logic [15:0]   msg_dest;
  logic [2:0]    msg_mode;

  int errors = 0, checks = 0, cycles = 0;
  int msg_cnt = 0;
  logic [7:0]  log_vec [32];
  logic [15:0] last_dest;
  logic [2:0]  last_mode;

  always #5 clk = ~clk;

  ioirq_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst && msg_valid && msg_ready) begin
      log_vec[msg_cnt % 32] = msg_vector;
      last_dest = msg_dest;
      last_mode = msg_mode;
      msg_cnt++;
    end
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(A_SEL, {24'd0, idx});
    wr(A_WIN, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
    wr(A_SEL, {24'd0, idx});
    rd(A_WIN, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(msg_valid == 1'b0, "R1 no message after reset", {31'd0, msg_valid}, 0);
    win_rd(8'h10, d);
    check(d == 32'h0001_0000, "R1 pin0 low word", d, 32'h0001_0000);
    win_rd(8'h11 + 8'd14, d);
    check(d == 32'h0, "R1 pin7 high word", d, 0);
    win_rd(8'h1E, d);
    check(d == 32'h0001_0000, "R1 pin7 low word", d, 32'h0001_0000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    win_rd(IDX_VER, d);
    check(d == 32'h0007_0021, "R3 version word", d, 32'h0007_0021);
    win_wr(IDX_VER, 32'hFFFF_FFFF);
    win_rd(IDX_VER, d);
    check(d == 32'h0007_0021, "R3 version write ignored", d, 32'h0007_0021);
    wr(A_SEL, 32'h0000_00A5);
    rd(A_SEL, d);
    check(d == 32'h0000_00A5, "R2 select readback", d, 32'h0000_00A5);
    win_wr(8'h05, 32'h1234_5678);
    win_rd(8'h05, d);
    check(d == 32'h0, "R2 unused index reads zero", d, 0);
    win_wr(8'h10 + 8'd16, 32'h0000_0000);
    win_rd(8'h10 + 8'd16, d);
    check(d == 32'h0, "R2 index past last pin reads zero", d, 0);
    win_wr(8'h12, 32'hFFFF_FFFF);
    win_rd(8'h12, d);
    check(d == 32'h0001_A7FF, "R4 low word fields only", d, 32'h0001_A7FF);
    win_wr(8'h13, 32'hFFFF_FFFF);
    win_rd(8'h13, d);
    check(d == 32'hFFFF_0000, "R4 high word dest only", d, 32'hFFFF_0000);
    win_wr(8'h12, 32'h0001_0000);
    win_rd(8'h12, d);
    check(d == 32'h0001_0000, "R4 low word rewrite", d, 32'h0001_0000);
    idle(10);
    check(msg_cnt == 0, "R6 masked pin sends nothing", msg_cnt, 0);
  endtask

  task automatic t_edge();
    int base;
    win_wr(8'h15, 32'h1234_0000);
    win_wr(8'h14, 32'h0000_0142);
    idle(5);
    base = msg_cnt;
    irq_in[2] = 1'b1;
    idle(12);
    check(msg_cnt == base + 1, "R5 one message on rising edge", msg_cnt, base + 1);
    check(log_vec[base % 32] == 8'h42, "R8 vector", log_vec[base % 32], 8'h42);
    check(last_dest == 16'h1234, "R8 destination", last_dest, 16'h1234);
    check(last_mode == 3'd1, "R8 mode lowest priority", last_mode, 1);
    idle(10);
    check(msg_cnt == base + 1, "R5 held level gives no repeat", msg_cnt, base + 1);
    irq_in[2] = 1'b0;
    idle(6);
    irq_in[2] = 1'b1;
    idle(12);
    check(msg_cnt == base + 2, "R5 second edge delivers", msg_cnt, base + 2);
    irq_in[2] = 1'b0;
    idle(6);
  endtask

  task automatic t_masked_edge();
    int base;
    logic [31:0] d;
    win_rd(8'h14, d);
    win_wr(8'h14, d | 32'h0001_0000);
    base = msg_cnt;
    irq_in[2] = 1'b1;
    idle(6);
    irq_in[2] = 1'b0;
    idle(6);
    irq_in[2] = 1'b1;
    idle(8);
    win_rd(8'h14, d);
    check(d == 32'h0001_0142, "R6 read-modify-write result", d, 32'h0001_0142);
    win_wr(8'h14, d & ~32'h0001_0000);
    idle(12);
    check(msg_cnt == base, "R6 no late delivery after unmask", msg_cnt, base);
    irq_in[2] = 1'b0;
    idle(6);
    irq_in[2] = 1'b1;
    idle(12);
    check(msg_cnt == base + 1, "R6 edge after unmask delivers", msg_cnt, base + 1);
    irq_in[2] = 1'b0;
  endtask

  task automatic t_level();
    int base;
    win_wr(8'h17, 32'hBEEF_0000);
    win_wr(8'h16, 32'h0000_A055);
    idle(10);
    base = msg_cnt;
    check(msg_cnt == base, "R11 high input inactive when active low", msg_cnt, base);
    irq_in[3] = 1'b0;
    idle(12);
    check(msg_cnt == base + 1, "R11 low input delivers", msg_cnt, base + 1);
    check(last_dest == 16'hBEEF, "R8 level destination", last_dest, 16'hBEEF);
    idle(20);
    check(msg_cnt == base + 1, "R7 blocked until EOI", msg_cnt, base + 1);
    wr(A_EOI, 32'h0000_0099);
    idle(10);
    check(msg_cnt == base + 1, "R7 other vector EOI no effect", msg_cnt, base + 1);
    wr(A_EOI, 32'h0000_0055);
    idle(10);
    check(msg_cnt == base + 2, "R7 matching EOI redelivers", msg_cnt, base + 2);
    irq_in[3] = 1'b1;
    idle(6);
    wr(A_EOI, 32'h0000_0055);
    idle(10);
    check(msg_cnt == base + 2, "R7 EOI with input inactive", msg_cnt, base + 2);
  endtask

  task automatic t_priority();
    int base;
    win_wr(8'h18, 32'h0000_0564);
    win_wr(8'h1A, 32'h0000_0265);
    idle(4);
    base = msg_cnt;
    msg_ready = 1'b0;
    irq_in[5] = 1'b1;
    irq_in[4] = 1'b1;
    idle(10);
    check(msg_valid == 1'b1, "R10 request raised", {31'd0, msg_valid}, 1);
    check(msg_vector == 8'h64, "R9 lowest pin first", msg_vector, 8'h64);
    idle(8);
    check(msg_valid == 1'b1 && msg_vector == 8'h64 && msg_mode == 3'd5,
          "R10 held while stalled", {msg_valid, 20'd0, msg_mode, msg_vector}, {1'b1, 20'd0, 3'd5, 8'h64});
    msg_ready = 1'b1;
    idle(10);
    check(msg_cnt == base + 2, "R9 both pins delivered", msg_cnt, base + 2);
    check(log_vec[base % 32] == 8'h64 && log_vec[(base + 1) % 32] == 8'h65,
          "R9 order", {log_vec[base % 32], log_vec[(base + 1) % 32]}, 16'h6465);
    check(last_mode == 3'd2, "R8 mode PMI", last_mode, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_masked_edge();
    t_level();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule